// File: doc/BRIEF.md
# Debug Event Ownership Router

This block sits between a processor core's debug event detectors and the two ways those events can be delivered. An external debugger can halt the core into debug mode. Software can take a debug interrupt. The block holds twelve debug resources. A 12-bit ownership register, written only through the debug port, gives each resource a runtime owner. While external debug mode is on, a 1 in that register hands the resource to the hardware debugger and a 0 leaves it with software. While external debug mode is off, the register has no effect and software owns every resource.

Each accepted event sets a bit in a 32-bit status word. Software clears bits in that word by writing ones to them. A hardware-owned event also raises a debug-mode request, which stays up until the debugger acknowledges it. The debug interrupt is a level output. It is recomputed from the status word and the enable inputs every cycle. The status word also records three further things:
- whether the instruction behind the event used the variable-length encoding;
- the offset of a data-address-compare event;
- an imprecise flag, for a data-address-compare event that coincides with a data storage error.

Top module: `dbg_evt_router`

## Requirements
- R1: Reset is synchronous and active low. After reset, the status word, the ownership register, `dbg_req_o` and `irq_o` are all zero.
- R2: `evt_i` bit k maps to a status bit given in big-endian numbering, where big-endian bit n is vector bit 31-n. The map is: k0 unimplemented-opcode→1, k1 instruction-complete→4, k2 branch→5, k3 interrupt-taken→6, k4 trap→7, k5 instruction-address→8, k6 data-address→9, k7 return→16, k8 external-event-1→21, k9 external-event-2→22, k10 critical-interrupt-taken→25, k11 critical-return→26. When `edm_i`=0 the ownership register is ignored and every event is software-owned. A software-owned event sets its bit one cycle later only if `idm_i`=1.
- R3: When `edm_i`=1, a resource whose ownership bit is 1 is hardware-owned. Its event sets its status bit whatever `idm_i` is, and it raises `dbg_req_o` in the next cycle.
- R4: `dbg_req_o` stays high until a cycle with `dbg_ack_i`=1, and drops in the cycle after that. If a new hardware-owned event arrives in the same cycle as the acknowledge, the request stays high.
- R5: `irq_o` is combinational. It is 1 exactly when `msr_de_i`=1, `idm_i`=1, and either some set resource status bit is software-owned or the imprecise bit is set while the data-address resource is software-owned.
- R6: The reset-record bit (big-endian 2, set by `mrr_i`) and the variable-length status bit (big-endian 27) never cause `irq_o`.
- R7: The variable-length bit is set when `evt_vle_i`=1 and an accepted event is one of k1, k2, k4, k5, k6, k7 or k11. Accepted events on k0, k3, k8, k9 or k10 leave the bit unchanged.
- R8: An accepted data-address event loads the 2-bit offset field at big-endian 29:30 (vector bits 2:1) from `dac_ofst_i`. If `dse_i`=1 in that same cycle, the field is loaded with 00 instead and the imprecise bit (big-endian 0) is set.
- R9: A software write with `sw_addr_i`=0 clears every status bit whose data bit is 1. A clear and a new event on the same bit in the same cycle leave the bit set.
- R10: The ownership register changes only on `dp_we_i`. Software writes with `sw_addr_i`=1 are ignored. A read at `sw_addr_i`=1 returns the register in bits 11:0, with zeros above.
- R11: Status bits outside the positions named in R2, R6, R7 and R8 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| edm_i | input | 1 | External debug mode enable |
| idm_i | input | 1 | Internal debug mode enable |
| msr_de_i | input | 1 | Software debug interrupt enable |
| evt_i | input | 12 | Per-resource event pulses |
| evt_vle_i | input | 1 | The event's instruction uses the variable-length encoding |
| dac_ofst_i | input | 2 | Offset reported with a data-address event |
| dse_i | input | 1 | Data storage error alongside a data-address event |
| mrr_i | input | 1 | Pulse that sets the reset-record bit |
| dp_we_i | input | 1 | Debug-port write strobe for the ownership register |
| dp_wdata_i | input | 12 | Debug-port ownership data, 1 = hardware |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | 1 | 0 = status word, 1 = ownership register |
| sw_wdata_i | input | 32 | Software write data (write-one-to-clear for status) |
| dbg_ack_i | input | 1 | Debugger acknowledge of the debug-mode request |
| sw_rdata_o | output | 32 | Software read data selected by `sw_addr_i` |
| stat_o | output | 32 | Status word |
| dbg_req_o | output | 1 | Debug-mode entry request |
| irq_o | output | 1 | Debug interrupt request |

## Verification
The hardest state to reach from the ports is a status word whose only set bits are the variable-length bit and the reset-record bit. Both enables must be high at that point, so any leftover resource bit would raise the interrupt and hide the behaviour under test. The stimulus reaches it in three steps:
1. Hand a VLE-capable resource to the debugger and fire it with `evt_vle_i` high.
2. Clear only that resource's bit with a one-hot write-one-to-clear, then pulse `mrr_i`.
3. Raise both enables.

A second hard case is an acknowledge that lands in the same cycle as a fresh hardware-owned event. The stimulus builds it directly, and a long random phase with a fixed seed covers further overlaps.

// File: rtl/dbg_evt_router.sv
module dbg_evt_router (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        edm_i,
  input  logic        idm_i,
  input  logic        msr_de_i,
  input  logic [11:0] evt_i,
  input  logic        evt_vle_i,
  input  logic [1:0]  dac_ofst_i,
  input  logic        dse_i,
  input  logic        mrr_i,
  input  logic        dp_we_i,
  input  logic [11:0] dp_wdata_i,
  input  logic        sw_we_i,
  input  logic        sw_addr_i,
  input  logic [31:0] sw_wdata_i,
  input  logic        dbg_ack_i,
  output logic [31:0] sw_rdata_o,
  output logic [31:0] stat_o,
  output logic        dbg_req_o,
  output logic        irq_o
);
  localparam int NRES = 12;
  localparam int RES_BE [NRES] = '{1, 4, 5, 6, 7, 8, 9, 16, 21, 22, 25, 26};
  localparam logic [NRES-1:0] VLE_CAP = 12'h8F6;
  localparam int DAC_R   = 6;
  localparam int IDE_IX  = 31 - 0;
  localparam int MRR_IX  = 31 - 2;
  localparam int VLES_IX = 31 - 27;
  localparam logic [31:0] VALID = 32'hEFC0_8676;

  logic [NRES-1:0] own_q, hw_own, acc, res_stat;
  logic [31:0]     stat_q, setv, clr, stat_d;
  logic            req_q, hw_hit;

  assign hw_own = edm_i ? own_q : '0;
  assign acc    = evt_i & (hw_own | {NRES{idm_i}});
  assign hw_hit = |(evt_i & hw_own);
  assign clr    = (sw_we_i && !sw_addr_i) ? sw_wdata_i : '0;

  always_comb begin
    setv = '0;
    for (int k = 0; k < NRES; k++) begin
      setv[31-RES_BE[k]] = acc[k];
      res_stat[k]        = stat_q[31-RES_BE[k]];
    end
    setv[VLES_IX] = evt_vle_i & |(acc & VLE_CAP);
    setv[IDE_IX]  = acc[DAC_R] & dse_i;
    setv[MRR_IX]  = mrr_i;
    stat_d = (stat_q & ~clr) | setv;
    if (acc[DAC_R]) stat_d[2:1] = dse_i ? 2'b00 : dac_ofst_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q <= '0;
      own_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (dp_we_i) own_q <= dp_wdata_i;
      if (hw_hit) req_q <= 1'b1;
      else if (dbg_ack_i) req_q <= 1'b0;
    end
  end

  assign stat_o     = stat_q;
  assign dbg_req_o  = req_q;
  assign sw_rdata_o = sw_addr_i ? {20'b0, own_q} : stat_q;
  assign irq_o      = msr_de_i & idm_i &
                      (|(res_stat & ~hw_own) | (stat_q[IDE_IX] & ~hw_own[DAC_R]));

  a_r3_hw_event_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edm_i && |(evt_i & own_q)) |=> dbg_req_o);
  a_r4_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && !dbg_ack_i) |=> dbg_req_o);
  a_r4_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && dbg_ack_i && !edm_i) |=> !dbg_req_o);
  a_r5_irq_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msr_de_i && idm_i));
  a_r9_ret_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edm_i && idm_i && evt_i[7]) |=> stat_o[31-16]);
  a_r10_own_port_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_we_i |=> $stable(own_q));
  a_r11_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~VALID) == 32'b0);
endmodule

// File: tb/dbg_evt_router_tb.sv
module dbg_evt_router_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic edm = 0, idm = 0, msr_de = 0, vle = 0, dse = 0, mrr = 0;
  logic dp_we = 0, sw_we = 0, sw_addr = 0, ack = 0;
  logic [11:0] evt = '0, dp_wdata = '0;
  logic [1:0]  ofst = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, stat;
  logic dbg_req, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  logic [31:0] m_stat = '0;
  logic [11:0] m_own = '0;
  logic        m_req = 0;
  int be_pos [12] = '{1, 4, 5, 6, 7, 8, 9, 16, 21, 22, 25, 26};
  int vle_list [$] = '{1, 2, 4, 5, 6, 7, 11};

  dbg_evt_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .edm_i(edm), .idm_i(idm), .msr_de_i(msr_de),
    .evt_i(evt), .evt_vle_i(vle), .dac_ofst_i(ofst), .dse_i(dse), .mrr_i(mrr),
    .dp_we_i(dp_we), .dp_wdata_i(dp_wdata), .sw_we_i(sw_we), .sw_addr_i(sw_addr),
    .sw_wdata_i(sw_wdata), .dbg_ack_i(ack), .sw_rdata_o(sw_rdata), .stat_o(stat),
    .dbg_req_o(dbg_req), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit hw_owned(int k);
    return edm && m_own[k];
  endfunction

  function automatic bit exp_irq();
    bit any = 0;
    if (!(msr_de && idm)) return 0;
    for (int k = 0; k < 12; k++)
      if (m_stat[31-be_pos[k]] && !hw_owned(k)) any = 1;
    if (m_stat[31] && !hw_owned(6)) any = 1;
    return any;
  endfunction

  task automatic cmp32(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] ns;
    bit anyhw, vset;
    #1;
    cmp32("stat", stat, m_stat);
    cmp32("dbg_req", {31'b0, dbg_req}, {31'b0, m_req});
    cmp32("irq", {31'b0, irq}, {31'b0, exp_irq()});
    cmp32("rdata", sw_rdata, sw_addr ? {20'b0, m_own} : m_stat);
    ns = m_stat;
    if (sw_we && !sw_addr) ns = ns & ~sw_wdata;
    anyhw = 0; vset = 0;
    for (int k = 0; k < 12; k++) begin
      if (evt[k] && (hw_owned(k) || idm)) begin
        ns[31-be_pos[k]] = 1'b1;
        if (hw_owned(k)) anyhw = 1;
        foreach (vle_list[i]) if (vle_list[i] == k && vle) vset = 1;
        if (k == 6) begin
          if (dse) begin ns[2:1] = 2'b00; ns[31] = 1'b1; end
          else ns[2:1] = ofst;
        end
      end
    end
    if (vset) ns[31-27] = 1'b1;
    if (mrr) ns[31-2] = 1'b1;
    if (!rst_n) begin
      m_stat = '0; m_own = '0; m_req = 0;
    end else begin
      m_stat = ns;
      if (dp_we) m_own = dp_wdata;
      if (anyhw) m_req = 1;
      else if (ack) m_req = 0;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    evt = '0; vle = 0; dse = 0; mrr = 0; dp_we = 0; sw_we = 0; ack = 0; sw_addr = 0;
  endtask

  task automatic fire(logic [11:0] e);
    evt = e; step(); evt = '0;
  endtask

  task automatic w1c(logic [31:0] d);
    sw_we = 1; sw_addr = 0; sw_wdata = d; step(); sw_we = 0;
  endtask

  task automatic own_wr(logic [11:0] d);
    dp_we = 1; dp_wdata = d; step(); dp_we = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(negedge clk);
    // R1: reset values
    cur_req = "R1"; step(); step();
    rst_n = 1; step();

    // R10: debug port writes ownership, software write ignored
    cur_req = "R10";
    own_wr(12'hFFF);
    sw_addr = 1; step();
    sw_we = 1; sw_wdata = 32'h0; step(); sw_we = 0; step(); sw_addr = 0;

    // R2: external mode off, ownership ignored, gated by idm
    cur_req = "R2";
    edm = 0; idm = 0; fire(12'hFFF); step();
    idm = 1; for (int k = 0; k < 12; k++) fire(12'(1) << k);
    msr_de = 1; step();
    cur_req = "R11"; w1c(32'hFFFF_FFFF); step();

    // R9: set wins over clear
    cur_req = "R9";
    fire(12'h080); evt = 12'h080; sw_we = 1; sw_wdata = 32'h0000_8000; step(); quiet(); step();
    w1c(32'h0000_8000); step();

    // R3 / R4: hardware-owned events
    cur_req = "R3";
    msr_de = 0; idm = 0; edm = 1; own_wr(12'h300);
    fire(12'h100); step(); fire(12'h001); step();
    cur_req = "R4";
    step(); ack = 1; step(); ack = 0; step();
    fire(12'h200); ack = 1; evt = 12'h200; step(); quiet(); step();
    ack = 1; step(); quiet(); step();
    w1c(32'hFFFF_FFFF);

    // R5: interrupt only for software-owned bits
    cur_req = "R5";
    idm = 1; msr_de = 1; fire(12'h100); step();
    fire(12'h400); step(); msr_de = 0; step(); msr_de = 1; idm = 0; step(); idm = 1;
    own_wr(12'h400); step(); edm = 0; step(); edm = 1;
    ack = 1; step(); quiet(); w1c(32'hFFFF_FFFF);

    // R6 / R7: VLES and MRR alone
    cur_req = "R7";
    own_wr(12'h002); idm = 0; msr_de = 0;
    vle = 1; fire(12'h002); vle = 0;
    cur_req = "R6";
    w1c(32'h0800_0000); mrr = 1; step(); mrr = 0;
    idm = 1; msr_de = 1; step(); step();
    ack = 1; step(); quiet(); w1c(32'hFFFF_FFFF);
    cur_req = "R7";
    vle = 1; fire(12'h008); fire(12'h100); fire(12'h001); fire(12'h400); step();
    fire(12'h800); vle = 0; step(); w1c(32'hFFFF_FFFF);

    // R8: data-address offset and imprecise flag
    cur_req = "R8";
    edm = 0; ofst = 2'b11; fire(12'h040); step();
    ofst = 2'b10; dse = 1; fire(12'h040); dse = 0; step();
    w1c(32'h8000_0000); step(); w1c(32'hFFFF_FFFF);

    // random mix across all requirements
    cur_req = "R2 R3 R4 R5 R7 R8 R9";
    for (int i = 0; i < 2000; i++) begin
      edm = $urandom_range(0, 1); idm = $urandom_range(0, 1); msr_de = $urandom_range(0, 1);
      evt = ($urandom_range(0, 3) == 0) ? 12'($urandom) : '0;
      vle = $urandom_range(0, 1); dse = $urandom_range(0, 1); ofst = 2'($urandom);
      mrr = ($urandom_range(0, 7) == 0); ack = $urandom_range(0, 1);
      dp_we = ($urandom_range(0, 15) == 0); dp_wdata = 12'($urandom);
      sw_we = $urandom_range(0, 1); sw_addr = $urandom_range(0, 1);
      sw_wdata = $urandom;
      step();
    end
    quiet(); step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule